// File: doc/BRIEF.md
# Dual-Mode PWM and Toggle Timer

This block drives two output pins, a low pin and a high pin, from a pair of 8-bit counters. The counters run either as two separate 8-bit channels or chained into one 16-bit channel. Each pin carries either a square wave that flips on a period match or an 8-bit pulse-width waveform. One mode runs a 16-bit toggle timer on the high pin while the low byte of the same counter produces PWM on the low pin. A host programs the block through a small write-only register port.

The configuration is a four-state machine held in a 2-bit mode register:

- TGL8: two 8-bit toggle timers.
- PWM8: two 8-bit PWM channels.
- TGL16: one 16-bit toggle timer, with the low byte also toggling the low pin.
- MIX16: a 16-bit toggle timer on the high pin and low-byte PWM on the low pin.

Reset enters TGL8. Every write to the control register takes the transition to the state named by the written value, and writing the current state is a restart.

Period and duty values are written to shadow registers. They reach the compare logic only at the next period boundary of the channel that uses them. Each channel also keeps a sticky flag that is set at its period boundary.

Top module: `dual_pwm_timer`

## Requirements
- R1: After reset both pins and both flags are 0, the state is TGL8 and every period and duty value is 0. A pin with period 0 in TGL8 therefore flips on every clock.
- R2: In TGL8, the low pin flips once every (PL+1) clocks and the high pin once every (PH+1) clocks. PL is the low period at address 1 and PH is the high period at address 2.
- R3: In PWM8, each counter wraps every 256 clocks. In each such period a pin is high for exactly D clocks, where D is its duty (low duty at address 3, high duty at address 4). A duty of 0 keeps the pin at 0.
- R4: In TGL16, the 16-bit count {high,low} restarts after reaching {PH,PL}, and the high pin flips at that match. The low pin flips on every clock whose low byte equals PL, and this includes the 16-bit match.
- R5: In MIX16, the low byte always counts over 256 clocks and drives the low pin as PWM with the low duty. The high byte advances on each low-byte wrap, and the high pin flips every (PH+1)*256 clocks. PL has no effect in this state.
- R6: A write to address 0 loads the state from bits 1:0 (0=TGL8, 1=PWM8, 2=TGL16, 3=MIX16). On the clock edge that samples the write, it clears both counters and both pins and loads all shadow values into the active compare registers.
- R7: A period or duty write does not change the running waveform until the next boundary of its channel. That boundary is a low or high match in TGL8, a byte wrap in PWM8, the 16-bit match in TGL16, and in MIX16 the low wrap for the low values and the 16-bit match for the high values.
- R8: The low flag is set at each low-channel boundary and the high flag at each high or 16-bit boundary. A flag stays set until the host writes address 5 with bit 0 (low) or bit 1 (high) set. A boundary in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counters advance on every rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1-2 periods, 3-4 duties, 5 flag clear) |
| wr_data | input | 8 | Register write data |
| pwm_lo | output | 1 | Low output pin |
| pwm_hi | output | 1 | High output pin |
| flag_lo | output | 1 | Sticky low-channel boundary flag |
| flag_hi | output | 1 | Sticky high-channel boundary flag |

## Verification
The assertions assume that the host issues at most one write per clock and that an unused address has no effect. They also take any write to address 0 as a restart, so that the count bounds and the stability of the active registers are judged only between such writes. The stimulus writes the shadow values first and the control register last. Mid-period writes are timed so that the old and new values give different pin levels, which makes the double buffering visible at the pins.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
    typedef enum logic [1:0] {
        M_TGL8  = 2'd0,
        M_PWM8  = 2'd1,
        M_TGL16 = 2'd2,
        M_MIX16 = 2'd3
    } mode_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_PER_LO  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PER_HI  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DUTY_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_DUTY_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLR     = 3'd5;
endpackage

// File: rtl/dpt_regs.sv
module dpt_regs
    import dpt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output mode_e             mode,
    output logic [CW-1:0]     per_lo_s,
    output logic [CW-1:0]     per_hi_s,
    output logic [CW-1:0]     duty_lo_s,
    output logic [CW-1:0]     duty_hi_s,
    output logic              restart,
    output logic [1:0]        clr
);
    // state register: the configuration state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= M_TGL8;
            per_lo_s  <= '0;
            per_hi_s  <= '0;
            duty_lo_s <= '0;
            duty_hi_s <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:    mode      <= mode_e'(wr_data[1:0]);
                A_PER_LO:  per_lo_s  <= wr_data;
                A_PER_HI:  per_hi_s  <= wr_data;
                A_DUTY_LO: duty_lo_s <= wr_data;
                A_DUTY_HI: duty_hi_s <= wr_data;
                default:   ;
            endcase
        end
    end

    // transition strobes
    always_comb begin
        restart = wr_en && (wr_addr == A_CTRL);
        clr     = (wr_en && (wr_addr == A_CLR)) ? wr_data[1:0] : 2'b00;
    end
endmodule

// File: rtl/dpt_core.sv
module dpt_core
    import dpt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  mode_e         mode,
    input  logic [CW-1:0] per_lo_s,
    input  logic [CW-1:0] per_hi_s,
    input  logic [CW-1:0] duty_lo_s,
    input  logic [CW-1:0] duty_hi_s,
    output logic [1:0]    tgl,
    output logic [1:0]    bnd,
    output logic [1:0]    lvl
);
    localparam int FW = 2 * CW;

    logic [CW-1:0] cnt_lo, cnt_hi, nxt_lo, nxt_hi;
    logic [CW-1:0] pl, ph, dl, dh;
    logic [FW-1:0] cat, cat_inc;
    logic          wrap_lo, wrap_hi, hit_lo, hit_hi, hit16, hit_mix;
    logic          ld_lo, ld_hi;

    always_comb begin
        cat     = {cnt_hi, cnt_lo};
        cat_inc = cat + 1'b1;
        wrap_lo = &cnt_lo;
        wrap_hi = &cnt_hi;
        hit_lo  = (cnt_lo == pl);
        hit_hi  = (cnt_hi == ph);
        hit16   = (cat == {ph, pl});
        hit_mix = wrap_lo && hit_hi;
        lvl     = {(cnt_hi < dh), (cnt_lo < dl)};
    end

    // next-count and event decode per configuration state
    always_comb begin
        nxt_lo = cnt_lo + 1'b1;
        nxt_hi = cnt_hi + 1'b1;
        tgl    = 2'b00;
        bnd    = 2'b00;
        ld_lo  = 1'b0;
        ld_hi  = 1'b0;
        unique case (mode)
            M_TGL8: begin
                if (hit_lo) nxt_lo = '0;
                if (hit_hi) nxt_hi = '0;
                tgl   = {hit_hi, hit_lo};
                bnd   = {hit_hi, hit_lo};
                ld_lo = hit_lo;
                ld_hi = hit_hi;
            end
            M_PWM8: begin
                bnd   = {wrap_hi, wrap_lo};
                ld_lo = wrap_lo;
                ld_hi = wrap_hi;
            end
            M_TGL16: begin
                {nxt_hi, nxt_lo} = hit16 ? '0 : cat_inc;
                tgl   = {hit16, hit_lo};
                bnd   = {hit16, hit_lo};
                ld_lo = hit16;
                ld_hi = hit16;
            end
            M_MIX16: begin
                if (hit_mix)      nxt_hi = '0;
                else if (!wrap_lo) nxt_hi = cnt_hi;
                tgl   = {hit_mix, 1'b0};
                bnd   = {hit_mix, wrap_lo};
                ld_lo = wrap_lo;
                ld_hi = hit_mix;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
            pl     <= '0;
            ph     <= '0;
            dl     <= '0;
            dh     <= '0;
        end else if (restart) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
            pl     <= per_lo_s;
            ph     <= per_hi_s;
            dl     <= duty_lo_s;
            dh     <= duty_hi_s;
        end else begin
            cnt_lo <= nxt_lo;
            cnt_hi <= nxt_hi;
            if (ld_lo) begin
                pl <= per_lo_s;
                dl <= duty_lo_s;
            end
            if (ld_hi) begin
                ph <= per_hi_s;
                dh <= duty_hi_s;
            end
        end
    end

    // R2: an 8-bit toggle count never passes its active period
    p_lo_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_TGL8) |-> (cnt_lo <= pl));

    // R7: active low values change only at a boundary or restart
    p_act_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !ld_lo) |=> ($stable(dl) && $stable(pl)));

    // R5: in MIX16 the high byte advances only on a low wrap
    p_mix_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_MIX16 && !restart && !wrap_lo) |=> $stable(cnt_hi));
endmodule

// File: rtl/dpt_pin.sv
module dpt_pin
    import dpt_pkg::*;
#(
    parameter bit HIGH_SIDE = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  mode_e mode,
    input  logic  tgl,
    input  logic  bnd,
    input  logic  lvl,
    input  logic  clr,
    output logic  pin,
    output logic  flag
);
    logic use_pwm;

    generate
        if (HIGH_SIDE) begin : g_hi
            assign use_pwm = (mode == M_PWM8);
        end else begin : g_lo
            assign use_pwm = (mode == M_PWM8) || (mode == M_MIX16);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (restart) begin
            pin <= 1'b0;
        end else if (use_pwm) begin
            pin <= lvl;
        end else if (tgl) begin
            pin <= ~pin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (bnd) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R2: a toggle pin holds without a toggle event
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !use_pwm && !tgl) |=> $stable(pin));

    // R6: restart clears the pin
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !pin);

    // R8: sticky until cleared, cleared when no boundary competes
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !bnd) |=> !flag);
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
    import dpt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CW-1:0]     wr_data,
    output logic              pwm_lo,
    output logic              pwm_hi,
    output logic              flag_lo,
    output logic              flag_hi
);
    localparam int NCH = 2;

    mode_e         mode;
    logic [CW-1:0] per_lo_s, per_hi_s, duty_lo_s, duty_hi_s;
    logic          restart;
    logic [1:0]    clr, tgl, bnd, lvl;
    logic [NCH-1:0] pin_v, flag_v;

    dpt_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mode      (mode),
        .per_lo_s  (per_lo_s),
        .per_hi_s  (per_hi_s),
        .duty_lo_s (duty_lo_s),
        .duty_hi_s (duty_hi_s),
        .restart   (restart),
        .clr       (clr)
    );

    dpt_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .mode      (mode),
        .per_lo_s  (per_lo_s),
        .per_hi_s  (per_hi_s),
        .duty_lo_s (duty_lo_s),
        .duty_hi_s (duty_hi_s),
        .tgl       (tgl),
        .bnd       (bnd),
        .lvl       (lvl)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_pin
        dpt_pin #(.HIGH_SIDE(i == 1)) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .mode    (mode),
            .tgl     (tgl[i]),
            .bnd     (bnd[i]),
            .lvl     (lvl[i]),
            .clr     (clr[i]),
            .pin     (pin_v[i]),
            .flag    (flag_v[i])
        );
    end

    assign pwm_lo  = pin_v[0];
    assign pwm_hi  = pin_v[1];
    assign flag_lo = flag_v[0];
    assign flag_hi = flag_v[1];
endmodule

// File: tb/test_dual_pwm_timer.sv
module test_dual_pwm_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_lo, pwm_hi, flag_lo, flag_hi;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    dual_pwm_timer i_dual_pwm_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_lo  (pwm_lo),
        .pwm_hi  (pwm_hi),
        .flag_lo (flag_lo),
        .flag_hi (flag_hi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sel(input bit hi);
        return hi ? pwm_hi : pwm_lo;
    endfunction

    task automatic gap(input bit hi, output int n);
        logic p;
        p = sel(hi);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sel(hi) == p && n < 3000);
    endtask

    task automatic highs(input bit hi, input int len, output int h);
        h = 0;
        repeat (len) begin
            @(negedge clk);
            if (sel(hi)) h++;
        end
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        tick(3);
        chk("R1 pwm_lo in reset", pwm_lo, 0);
        chk("R1 pwm_hi in reset", pwm_hi, 0);
        chk("R1 flag_lo in reset", flag_lo, 0);
        chk("R1 flag_hi in reset", flag_hi, 0);
        rst_n = 1'b1;
        gap(1'b0, n);
        chk("R1 zero period toggles each clock", n, 1);
    endtask

    task automatic t_toggle8();
        int n;
        wr(3'd1, 8'd4); wr(3'd2, 8'd9); wr(3'd0, 8'd0);
        gap(1'b0, n); chk("R2 low first interval", n, 5);
        gap(1'b0, n); chk("R2 low interval", n, 5);
        wr(3'd0, 8'd0);
        gap(1'b1, n); chk("R2 high first interval", n, 10);
        gap(1'b1, n); chk("R2 high interval", n, 10);
    endtask

    task automatic t_pwm8();
        int h;
        wr(3'd3, 8'd64); wr(3'd4, 8'd200); wr(3'd0, 8'd1);
        highs(1'b0, 256, h); chk("R3 low duty 64", h, 64);
        highs(1'b1, 256, h); chk("R3 high duty 200", h, 200);
        wr(3'd3, 8'd0); tick(256);
        highs(1'b0, 256, h); chk("R3 duty 0 stays low", h, 0);
        wr(3'd3, 8'd255); tick(256);
        highs(1'b0, 256, h); chk("R3 duty 255", h, 255);
    endtask

    task automatic t_buffer();
        int h, n;
        wr(3'd3, 8'd64); wr(3'd0, 8'd1);
        tick(100);
        wr(3'd3, 8'd128);
        highs(1'b0, 100, h); chk("R7 duty held until wrap", h, 0);
        tick(100);
        highs(1'b0, 256, h); chk("R7 new duty after wrap", h, 128);
        wr(3'd1, 8'd255); wr(3'd0, 8'd0);
        gap(1'b0, n); chk("R7 long period", n, 256);
        wr(3'd1, 8'd4);
        gap(1'b0, n); chk("R7 period held until match", n, 254);
        gap(1'b0, n); chk("R7 new period after match", n, 5);
    endtask

    task automatic t_tgl16();
        int n;
        wr(3'd1, 8'd3); wr(3'd2, 8'd1); wr(3'd0, 8'd2);
        gap(1'b0, n); chk("R4 low byte match", n, 4);
        gap(1'b0, n); chk("R4 low at 16-bit match", n, 256);
        gap(1'b0, n); chk("R4 low after wrap", n, 4);
        wr(3'd0, 8'd2);
        gap(1'b1, n); chk("R4 high 16-bit period", n, 260);
        gap(1'b1, n); chk("R4 high 16-bit period again", n, 260);
    endtask

    task automatic t_mix16();
        int n, h;
        wr(3'd2, 8'd2); wr(3'd3, 8'd32); wr(3'd0, 8'd3);
        gap(1'b1, n); chk("R5 high period 3*256", n, 768);
        highs(1'b0, 256, h); chk("R5 low byte PWM", h, 32);
    endtask

    task automatic t_restart();
        int n;
        wr(3'd1, 8'd2); wr(3'd0, 8'd0);
        gap(1'b0, n); chk("R6 pin set before restart", pwm_lo, 1);
        wr(3'd0, 8'd0);
        chk("R6 low cleared by restart", pwm_lo, 0);
        chk("R6 high cleared by restart", pwm_hi, 0);
        gap(1'b0, n); chk("R6 count restarted", n, 3);
    endtask

    task automatic t_flags();
        int n;
        wr(3'd1, 8'd255); wr(3'd2, 8'd255); wr(3'd0, 8'd0);
        wr(3'd5, 8'd3);
        chk("R8 flag_lo cleared", flag_lo, 0);
        chk("R8 flag_hi cleared", flag_hi, 0);
        gap(1'b0, n);
        chk("R8 flag_lo set at match", flag_lo, 1);
        chk("R8 flag_hi set at match", flag_hi, 1);
        wr(3'd5, 8'd1);
        chk("R8 flag_lo cleared by bit 0", flag_lo, 0);
        chk("R8 flag_hi kept", flag_hi, 1);
        tick(50);
        chk("R8 flag_hi sticky", flag_hi, 1);
    endtask

    initial begin
        t_reset();
        t_toggle8();
        t_pwm8();
        t_buffer();
        t_tgl16();
        t_mix16();
        t_restart();
        t_flags();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule